// File: doc/BRIEF.md
# 4:2:2 Component Stream Demultiplexer

This block receives one multiplexed 4:2:2 component video stream, one 10-bit word per rising clock edge, in the repeating order blue-difference (Cb), luma (Y), red-difference (Cr), luma (Y). It splits the stream into three 10-bit channels. Each luma word comes out with a one-cycle valid strobe. Each co-sited Cb/Cr pair comes out together with a separate one-cycle strobe. A 2-bit phase output tells later interpolation stages which slot of the group was just captured.

The word phase is aligned by a control input, `sync_i`. When it is high in one cycle and low in the next, the word present in the low cycle is taken as Cb. After that, `sync_i` may stay low and the phase free-runs, or it may pulse before every Cb, which re-asserts the same alignment. All code words, including extreme or reserved values, pass through unchanged. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `ycc422_demux`

## Requirements
- R1: While reset is active, `y_o`, `cb_o` and `cr_o` are zero, `y_vld_o` and `c_vld_o` are low, and `phase_o` is 0. Reset takes effect at once and releases on the second rising edge after `rst_n` rises.
- R2: If `sync_i` was high in the previous cycle and is low in the current cycle, the current input word is captured as Cb (phase 0).
- R3: With no high-to-low transition of `sync_i`, the phase of each captured word is the previous phase plus one, modulo 4. The phase codes are 0 for Cb, 1 for the first Y, 2 for Cr and 3 for the second Y.
- R4: Pulsing `sync_i` high in the cycle before each Cb leaves an already correct alignment undisturbed.
- R5: `y_vld_o` is high for exactly the one cycle after a word of phase 1 or 3 is captured, and `y_o` then equals that word.
- R6: `c_vld_o` is high for exactly the one cycle after a Cr word is captured. `cr_o` then equals that word and `cb_o` equals the Cb word of the same group. The two valids are never high together.
- R7: `y_o` holds its value while `y_vld_o` is low, and `cb_o`/`cr_o` hold their values while `c_vld_o` is low.
- R8: Code words pass through bit-exact, including 0x000, 0x3FF and alternating bit patterns.
- R9: A high-to-low transition of `sync_i` re-aligns the phase to 0 even in the middle of a group. While `sync_i` stays high, the phase keeps advancing.
- R10: `phase_o` shows, one cycle after each input word, the phase that word was captured in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_i | input | 1 | Alignment control; a fall marks the current word as Cb |
| din_i | input | 10 | Multiplexed 4:2:2 input word, bit 9 MSB |
| y_o | output | 10 | Luma sample |
| y_vld_o | output | 1 | Luma valid strobe |
| cb_o | output | 10 | Blue-difference sample of the current pair |
| cr_o | output | 10 | Red-difference sample of the current pair |
| c_vld_o | output | 1 | Chroma pair valid strobe |
| phase_o | output | 2 | Phase of the word captured on the last edge |

## Verification
The assertions assume that `din_i` and `sync_i` settle well before each rising edge, and that phase relations are judged only after the first active edge following reset release, because the first step after reset comes from the reset value and not from the previous output. The bench drives every input on the falling edge and reads outputs just after the rising edge, so each vector lands on exactly one capture edge. After release it waits exactly two edges so that the first vector is the first word captured.

// File: rtl/ycc422_demux_pkg.sv
package ycc422_demux_pkg;
  localparam int unsigned GROUP_LEN = 4;
  localparam int unsigned PH_W      = $clog2(GROUP_LEN);

  typedef enum logic [PH_W-1:0] {
    SLOT_CB = 2'd0,
    SLOT_Y0 = 2'd1,
    SLOT_CR = 2'd2,
    SLOT_Y1 = 2'd3
  } slot_t;
endpackage

// File: rtl/ycc422_rst_sync.sv
module ycc422_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/ycc422_en_reg.sv
module ycc422_en_reg #(
  parameter int unsigned W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/ycc422_phase_tracker.sv
module ycc422_phase_tracker
  import ycc422_demux_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  sync_i,
  output slot_t cur_slot
);
  logic  sync_q;
  slot_t slot_q, slot_d;
  logic  sync_fall;

  // a fall is seen in the cycle whose word is the Cb
  assign sync_fall = sync_q & ~sync_i;

  always_comb begin
    cur_slot = sync_fall ? SLOT_CB : slot_q;
    slot_d   = slot_t'(cur_slot + 2'd1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 1'b0;
      slot_q <= SLOT_CB;
    end else begin
      sync_q <= sync_i;
      slot_q <= slot_d;
    end
  end
endmodule

// File: rtl/ycc422_lane_capture.sv
module ycc422_lane_capture
  import ycc422_demux_pkg::*;
#(
  parameter int unsigned W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  slot_t           cur_slot,
  input  logic [W-1:0]    din,
  output logic [W-1:0]    y,
  output logic            y_vld,
  output logic [W-1:0]    cb,
  output logic [W-1:0]    cr,
  output logic            c_vld,
  output logic [PH_W-1:0] phase
);
  logic            en_y, en_cb, en_pair;
  logic [W-1:0]    cb_hold;
  logic            y_vld_d, c_vld_d;

  always_comb begin
    en_cb   = (cur_slot == SLOT_CB);
    en_pair = (cur_slot == SLOT_CR);
    en_y    = (cur_slot == SLOT_Y0) || (cur_slot == SLOT_Y1);
    y_vld_d = en_y;
    c_vld_d = en_pair;
  end

  ycc422_en_reg #(.W(W)) u_cb_hold (
    .clk(clk), .rst_n(rst_n), .en(en_cb),   .d(din),     .q(cb_hold));
  ycc422_en_reg #(.W(W)) u_y_out (
    .clk(clk), .rst_n(rst_n), .en(en_y),    .d(din),     .q(y));
  ycc422_en_reg #(.W(W)) u_cb_out (
    .clk(clk), .rst_n(rst_n), .en(en_pair), .d(cb_hold), .q(cb));
  ycc422_en_reg #(.W(W)) u_cr_out (
    .clk(clk), .rst_n(rst_n), .en(en_pair), .d(din),     .q(cr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_vld <= 1'b0;
      c_vld <= 1'b0;
      phase <= '0;
    end else begin
      y_vld <= y_vld_d;
      c_vld <= c_vld_d;
      phase <= cur_slot;
    end
  end
endmodule

// File: rtl/ycc422_demux.sv
module ycc422_demux
  import ycc422_demux_pkg::*;
#(
  parameter int unsigned W          = 10,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sync_i,
  input  logic [W-1:0] din_i,
  output logic [W-1:0] y_o,
  output logic         y_vld_o,
  output logic [W-1:0] cb_o,
  output logic [W-1:0] cr_o,
  output logic         c_vld_o,
  output logic [1:0]   phase_o
);
  logic  rst_int_n;
  slot_t cur_slot;

  ycc422_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n));

  ycc422_phase_tracker u_phase (
    .clk(clk), .rst_n(rst_int_n), .sync_i(sync_i), .cur_slot(cur_slot));

  ycc422_lane_capture #(.W(W)) u_lanes (
    .clk(clk), .rst_n(rst_int_n), .cur_slot(cur_slot), .din(din_i),
    .y(y_o), .y_vld(y_vld_o), .cb(cb_o), .cr(cr_o), .c_vld(c_vld_o),
    .phase(phase_o));
endmodule

// File: rtl/ycc422_demux_chk.sv
module ycc422_demux_chk #(
  parameter int unsigned W = 10
) (
  input logic         clk,
  input logic         rst_int_n,
  input logic         sync_i,
  input logic [W-1:0] din_i,
  input logic [W-1:0] y_o,
  input logic         y_vld_o,
  input logic [W-1:0] cb_o,
  input logic [W-1:0] cr_o,
  input logic         c_vld_o,
  input logic [1:0]   phase_o
);
  logic armed;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed <= 1'b0;
    else            armed <= 1'b1;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_int_n |-> (!y_vld_o && !c_vld_o && phase_o == 2'd0 && y_o == '0));

  a_r2_fall_aligns: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && $past(sync_i) && !sync_i) |=> phase_o == 2'd0);

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && !($past(sync_i) && !sync_i)) |=> phase_o == $past(phase_o) + 2'd1);

  a_r5_y_slot: assert property (@(posedge clk) disable iff (!rst_int_n)
    y_vld_o |-> phase_o[0]);

  a_r5_y_data: assert property (@(posedge clk) disable iff (!rst_int_n)
    y_vld_o |-> y_o == $past(din_i));

  a_r6_pair_slot: assert property (@(posedge clk) disable iff (!rst_int_n)
    c_vld_o |-> (phase_o == 2'd2 && cr_o == $past(din_i)));

  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0({y_vld_o, c_vld_o}));

  a_r7_y_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && !y_vld_o) |-> $stable(y_o));

  a_r7_pair_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    (armed && !c_vld_o) |-> ($stable(cb_o) && $stable(cr_o)));
endmodule

bind ycc422_demux ycc422_demux_chk #(.W(W)) u_chk (
  .clk(clk), .rst_int_n(rst_int_n), .sync_i(sync_i), .din_i(din_i),
  .y_o(y_o), .y_vld_o(y_vld_o), .cb_o(cb_o), .cr_o(cr_o),
  .c_vld_o(c_vld_o), .phase_o(phase_o));

// File: tb/ycc422_demux_bench.sv
module ycc422_demux_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int NVEC = 24;

  typedef struct packed {
    logic         sync;
    logic [W-1:0] din;
    logic [1:0]   ph;
    logic         yv;
    logic         cv;
    logic [W-1:0] cb;
  } vec_t;

  // sync, word, expected phase, luma strobe, pair strobe, expected Cb of pair
  localparam vec_t TAB [0:NVEC-1] = '{
    '{1'b1, 10'h100, 2'd0, 1'b0, 1'b0, 10'h000},
    '{1'b0, 10'h040, 2'd0, 1'b0, 1'b0, 10'h000}, // R2 first fall
    '{1'b0, 10'h050, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h060, 2'd2, 1'b0, 1'b1, 10'h040},
    '{1'b0, 10'h070, 2'd3, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h3FF, 2'd0, 1'b0, 1'b0, 10'h000}, // R3 free-run, R8 extremes
    '{1'b0, 10'h000, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h200, 2'd2, 1'b0, 1'b1, 10'h3FF},
    '{1'b1, 10'h123, 2'd3, 1'b1, 1'b0, 10'h000}, // R4 pulse before Cb
    '{1'b0, 10'h0AA, 2'd0, 1'b0, 1'b0, 10'h000},
    '{1'b0, 10'h155, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h2AA, 2'd2, 1'b0, 1'b1, 10'h0AA},
    '{1'b1, 10'h001, 2'd3, 1'b1, 1'b0, 10'h000}, // R4 second pulse
    '{1'b0, 10'h002, 2'd0, 1'b0, 1'b0, 10'h000},
    '{1'b0, 10'h003, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b1, 10'h004, 2'd2, 1'b0, 1'b1, 10'h002},
    '{1'b0, 10'h005, 2'd0, 1'b0, 1'b0, 10'h000}, // R9 mid-group realign
    '{1'b0, 10'h006, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h007, 2'd2, 1'b0, 1'b1, 10'h005},
    '{1'b1, 10'h008, 2'd3, 1'b1, 1'b0, 10'h000},
    '{1'b1, 10'h009, 2'd0, 1'b0, 1'b0, 10'h000}, // R9 high keeps counting
    '{1'b1, 10'h00A, 2'd1, 1'b1, 1'b0, 10'h000},
    '{1'b0, 10'h00B, 2'd0, 1'b0, 1'b0, 10'h000}, // R9 fall at slot 2
    '{1'b0, 10'h00C, 2'd1, 1'b1, 1'b0, 10'h000}
  };

  logic         clk;
  logic         rst_n;
  logic         sync_i;
  logic [W-1:0] din_i;
  logic [W-1:0] y_o, cb_o, cr_o;
  logic         y_vld_o, c_vld_o;
  logic [1:0]   phase_o;

  int total = 0;
  int bad   = 0;
  logic [W-1:0] last_y, last_cb, last_cr;

  ycc422_demux u_ycc422_demux (
    .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .din_i(din_i),
    .y_o(y_o), .y_vld_o(y_vld_o), .cb_o(cb_o), .cr_o(cr_o),
    .c_vld_o(c_vld_o), .phase_o(phase_o));

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic [W-1:0] d);
    @(negedge clk);
    sync_i = s;
    din_i  = d;
    @(posedge clk);
    #1;
  endtask

  task automatic check_reset(input string tag);
    check({tag, " R1 y_vld"}, 32'(y_vld_o), 0);
    check({tag, " R1 c_vld"}, 32'(c_vld_o), 0);
    check({tag, " R1 phase"}, 32'(phase_o), 0);
    check({tag, " R1 y"},     32'(y_o), 0);
    check({tag, " R1 cb"},    32'(cb_o), 0);
    check({tag, " R1 cr"},    32'(cr_o), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n  = 1'b0;
    sync_i = 1'b0;
    din_i  = '0;
    repeat (3) @(posedge clk);
    #1;
    check_reset("in reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_reset("after release");

    last_y = '0; last_cb = '0; last_cr = '0;
    for (int i = 0; i < NVEC; i++) begin
      step(TAB[i].sync, TAB[i].din);
      check($sformatf("R10 R3 phase row %0d", i), 32'(phase_o), 32'(TAB[i].ph));
      check($sformatf("R5 y_vld row %0d", i), 32'(y_vld_o), 32'(TAB[i].yv));
      check($sformatf("R6 c_vld row %0d", i), 32'(c_vld_o), 32'(TAB[i].cv));
      if (TAB[i].yv) begin
        last_y = TAB[i].din;
        check($sformatf("R8 y data row %0d", i), 32'(y_o), 32'(last_y));
      end else begin
        check($sformatf("R7 y hold row %0d", i), 32'(y_o), 32'(last_y));
      end
      if (TAB[i].cv) begin
        last_cb = TAB[i].cb;
        last_cr = TAB[i].din;
        check($sformatf("R6 cb row %0d", i), 32'(cb_o), 32'(last_cb));
        check($sformatf("R6 cr row %0d", i), 32'(cr_o), 32'(last_cr));
      end else begin
        check($sformatf("R7 cb hold row %0d", i), 32'(cb_o), 32'(last_cb));
        check($sformatf("R7 cr hold row %0d", i), 32'(cr_o), 32'(last_cr));
      end
    end

    // R1: asynchronous reset mid-stream clears everything at once
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check_reset("mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check_reset("second release");

    // R2: realign after second reset, Cb 0x111 then Y 0x222 then Cr 0x333
    step(1'b1, 10'h3C3);
    step(1'b0, 10'h111);
    check("R2 phase on Cb", 32'(phase_o), 0);
    step(1'b0, 10'h222);
    check("R5 y after realign", 32'(y_o), 32'h222);
    step(1'b0, 10'h333);
    check("R6 cb after realign", 32'(cb_o), 32'h111);
    check("R6 cr after realign", 32'(cr_o), 32'h333);
    check("R6 c_vld after realign", 32'(c_vld_o), 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule